// File: doc/BRIEF.md
# Clear Channel Assessment Decision Unit

This block decides whether the radio channel is busy or idle for a direct-sequence spread-spectrum receiver. Three detector flags come in on every clock: an energy-over-threshold flag, a carrier-sense flag from the correlator and a signal-quality flag. A 2-bit rule select chooses how the flags are combined. Each decision covers one assessment window. A 1-bit select sets the window to either about 18.7 µs or about 15.8 µs.

The whole microseconds of a window are counted on a one-microsecond timebase strobe. The fractional tail is then counted in clocks, and its length is derived from the `CLK_PER_US` parameter, rounded to the nearest clock. A flag counts for the window if it is high on any clock of that window. At the window's last clock, the chosen rule is applied to the collected flags. The registered busy output then takes the result, and a one-clock done pulse marks the update. The rule and window selects are captured at each window boundary, and again while reset is held.

Top module: `cca_decider`

## Requirements
- R1: While reset is held, and on the first clock after it, `busy` and `done` are 0. Reset restarts the window count and captures `comb_mode` and `win_sel` for the first window.
- R2: With rule 2'b00, a window decides busy when the energy flag was seen.
- R3: With rule 2'b01, a window decides busy when the carrier-sense flag or the quality flag was seen.
- R4: With rule 2'b10, a window decides busy when the energy flag was seen and at least one of carrier-sense or quality was seen.
- R5: With rule 2'b11, a window decides busy when any of the three flags was seen.
- R6: A flag that is high for a single clock anywhere in a window counts as seen for that window.
- R7: With `win_sel`=0, a window ends 7 clocks after its 18th `us_tick` (for `CLK_PER_US`=10). With `win_sel`=1, it ends 8 clocks after its 15th `us_tick`. The tail length is round(0.7·CLK_PER_US) or round(0.8·CLK_PER_US) clocks.
- R8: `done` is high for exactly one clock, in the clock after a window's last clock. `busy` changes only together with `done`.
- R9: A change of `comb_mode` or `win_sel` inside a window does not affect that window. It applies from the next window on.
- R10: Flags seen in one window do not carry into the next window's decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | One-clock strobe once per microsecond |
| ed_flag | input | 1 | Energy-over-threshold detector flag |
| cs_flag | input | 1 | Carrier-sense detector flag |
| sq_flag | input | 1 | Signal-quality detector flag |
| comb_mode | input | 2 | Combining rule: 00 energy, 01 cs or sq, 10 energy and (cs or sq), 11 any |
| win_sel | input | 1 | Window length: 0 about 18.7 µs, 1 about 15.8 µs |
| busy | output | 1 | Registered channel-busy decision |
| done | output | 1 | One-clock pulse with each decision update |

## Verification
The bench aims at flags that are high for one clock only, to catch a design that samples only at the window end rather than collecting over the whole window. It changes the rule in the middle of a window, to catch a design that applies a new rule to the window already running and so reports busy one window early. It runs a clean window after a busy one, to catch collected flags that are not cleared. It also measures the window length for both selects, to catch a tail that is off by one clock or a strobe count that is off by one microsecond, either of which shifts every done pulse.

// File: rtl/cca_decider.sv
module cca_decider #(
  parameter int CLK_PER_US   = 200,
  parameter int LONG_US      = 18,
  parameter int LONG_TENTHS  = 7,
  parameter int SHORT_US     = 15,
  parameter int SHORT_TENTHS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       us_tick,
  input  logic       ed_flag,
  input  logic       cs_flag,
  input  logic       sq_flag,
  input  logic [1:0] comb_mode,
  input  logic       win_sel,
  output logic       busy,
  output logic       done
);
  localparam int LONG_FRAC  = (CLK_PER_US * LONG_TENTHS + 5) / 10;
  localparam int SHORT_FRAC = (CLK_PER_US * SHORT_TENTHS + 5) / 10;
  localparam int MAX_FRAC   = (LONG_FRAC > SHORT_FRAC) ? LONG_FRAC : SHORT_FRAC;
  localparam int MAX_US     = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
  localparam int FW         = $clog2(MAX_FRAC + 1);
  localparam int UW         = $clog2(MAX_US + 1);

  logic [1:0]    mode_q;
  logic          win_q;
  logic          tail_q;
  logic [UW-1:0] us_cnt;
  logic [FW-1:0] frac_cnt;
  logic          ed_acc, cs_acc, sq_acc;
  logic          verdict;

  wire [UW-1:0] us_last   = win_q ? UW'(SHORT_US - 1) : UW'(LONG_US - 1);
  wire [FW-1:0] frac_last = win_q ? FW'(SHORT_FRAC - 1) : FW'(LONG_FRAC - 1);
  wire ed_w  = ed_acc | ed_flag;
  wire cs_w  = cs_acc | cs_flag;
  wire sq_w  = sq_acc | sq_flag;
  wire end_c = tail_q && (frac_cnt == frac_last);

  always_comb begin
    case (mode_q)
      2'b00:   verdict = ed_w;
      2'b01:   verdict = cs_w | sq_w;
      2'b10:   verdict = ed_w & (cs_w | sq_w);
      default: verdict = ed_w | cs_w | sq_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= comb_mode;
      win_q    <= win_sel;
      tail_q   <= 1'b0;
      us_cnt   <= '0;
      frac_cnt <= '0;
      ed_acc   <= 1'b0;
      cs_acc   <= 1'b0;
      sq_acc   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= end_c;
      if (end_c) begin
        busy     <= verdict;
        mode_q   <= comb_mode;
        win_q    <= win_sel;
        tail_q   <= 1'b0;
        us_cnt   <= '0;
        frac_cnt <= '0;
        ed_acc   <= 1'b0;
        cs_acc   <= 1'b0;
        sq_acc   <= 1'b0;
      end else begin
        ed_acc <= ed_w;
        cs_acc <= cs_w;
        sq_acc <= sq_w;
        if (tail_q) begin
          frac_cnt <= frac_cnt + 1'b1;
        end else if (us_tick) begin
          if (us_cnt == us_last) begin
            tail_q   <= 1'b1;
            frac_cnt <= '0;
          end else begin
            us_cnt <= us_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

module cca_decider_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       end_c,
  input logic [1:0] mode_q,
  input logic       ed_flag,
  input logic       cs_flag,
  input logic       sq_flag
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d) reset_clear_chk: assert (!busy && !done);
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(busy));

  // R2
  ed_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (end_c && mode_q == 2'b00 && ed_flag) |=> (busy && done));

  // R3
  cs_sq_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (end_c && mode_q == 2'b01 && (cs_flag || sq_flag)) |=> (busy && done));

  // R5
  any_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (end_c && mode_q == 2'b11 && (ed_flag || cs_flag || sq_flag)) |=> (busy && done));
endmodule

bind cca_decider cca_decider_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .end_c(end_c),
  .mode_q(mode_q), .ed_flag(ed_flag), .cs_flag(cs_flag), .sq_flag(sq_flag)
);

// File: tb/cca_decider_bench.sv
`timescale 1ns/1ps
module cca_decider_bench;
  localparam int P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic us_tick = 1'b0;
  logic ed = 1'b0, cs = 1'b0, sq = 1'b0;
  logic [1:0] mode = 2'b00;
  logic win = 1'b0;
  logic busy, done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cca_decider #(.CLK_PER_US(P)) u_cca_decider (
    .clk(clk), .rst(rst), .us_tick(us_tick), .ed_flag(ed), .cs_flag(cs),
    .sq_flag(sq), .comb_mode(mode), .win_sel(win), .busy(busy), .done(done)
  );

  bit [1:0] m_mode;
  bit m_win, m_busy, m_done, m_se, m_sc, m_ss, m_fin;
  int m_strobes, m_tail;
  string m_tag = "R1";

  function automatic bit rule(bit [1:0] md, bit e, bit c, bit s);
    case (md)
      2'd0: return e;
      2'd1: return c | s;
      2'd2: return e & (c | s);
      default: return e | c | s;
    endcase
  endfunction

  function automatic string rule_tag(bit [1:0] md);
    case (md)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_mode = mode; m_win = win;
      m_strobes = 0; m_tail = -1; m_se = 0; m_sc = 0; m_ss = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      m_fin = 0;
      m_se = m_se | ed; m_sc = m_sc | cs; m_ss = m_ss | sq;
      if (m_tail >= 0) begin
        m_tail++;
        if (m_tail == (m_win ? 8 : 7)) m_fin = 1;
      end else if (us_tick) begin
        m_strobes++;
        if (m_strobes == (m_win ? 15 : 18)) m_tail = 0;
      end
      if (m_fin) begin
        m_busy = rule(m_mode, m_se, m_sc, m_ss);
        m_tag = rule_tag(m_mode);
        m_done = 1;
        m_mode = mode; m_win = win;
        m_strobes = 0; m_tail = -1; m_se = 0; m_sc = 0; m_ss = 0;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      check({m_tag, " busy"}, busy, m_busy);
      check("R7/R8 done", done, m_done);
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic run_case(bit [1:0] md, bit w, bit e, bit c, bit s, bit exp, string tag);
    mode = md; win = w; ed = e; cs = c; sq = s;
    wait_done();
    wait_done();
    wait_done();
    check(tag, busy, exp);
  endtask

  task automatic measure(bit w, int lo, int hi);
    int n;
    win = w;
    wait_done();
    wait_done();
    n = 0;
    @(negedge clk);
    n++;
    while (done !== 1'b1) begin
      @(negedge clk);
      n++;
    end
    check("R7 window length", (n >= lo && n <= hi) ? 1 : 0, 1);
  endtask

  initial begin
    fork
      begin
        int ph = 0;
        forever begin
          @(negedge clk);
          ph = (ph + 1) % P;
          us_tick = (ph == 3);
        end
      end
    join_none

    repeat (4) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);

    wait_done();
    check("R2 idle window", busy, 0);
    repeat (40) @(negedge clk);
    ed = 1'b1;
    @(negedge clk);
    ed = 1'b0;
    wait_done();
    check("R6 single-clock energy pulse", busy, 1);
    wait_done();
    check("R10 no carry-over", busy, 0);

    cs = 1'b1;
    wait_done();
    wait_done();
    check("R2 cs ignored by rule 00", busy, 0);
    mode = 2'b01;
    wait_done();
    check("R9 rule change mid-window deferred", busy, 0);
    wait_done();
    check("R3 cs under rule 01", busy, 1);

    run_case(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 sq under rule 01");
    run_case(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 energy ignored by rule 01");
    run_case(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 energy alone");
    run_case(2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4 no energy");
    run_case(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R4 energy and sq");
    run_case(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 all quiet");
    run_case(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 sq alone");

    ed = 1'b0; cs = 1'b0; sq = 1'b0;
    measure(1'b1, (15 - 1) * P + 1 + 8, 15 * P + 8);
    measure(1'b0, (18 - 1) * P + 1 + 7, 18 * P + 7);

    mode = 2'b10;
    wait_done();
    wait_done();
    repeat (30) @(negedge clk);
    sq = 1'b1;
    @(negedge clk);
    sq = 1'b0;
    repeat (50) @(negedge clk);
    ed = 1'b1;
    @(negedge clk);
    ed = 1'b0;
    wait_done();
    check("R4 R6 separate one-clock pulses", busy, 1);

    for (int i = 0; i < 2400; i++) begin
      @(negedge clk);
      ed = ($urandom % 97) == 0;
      cs = ($urandom % 131) == 0;
      sq = ($urandom % 151) == 0;
      if ((i % 170) == 0) mode = 2'($urandom);
      if ((i % 430) == 0) win = 1'($urandom);
    end
    ed = 1'b0; cs = 1'b0; sq = 1'b0;

    mode = 2'b11;
    wait_done();
    wait_done();
    cs = 1'b1;
    repeat (60) @(negedge clk);
    rst = 1'b1;
    mode = 2'b00;
    cs = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset mid-window busy", busy, 0);
    rst = 1'b0;
    wait_done();
    check("R1 R10 fresh window after reset", busy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule